// File: doc/BRIEF.md
# DMA control register interface

This block is the software-facing register set of a DMA engine that takes its work from a table of channel descriptors kept in RAM. It holds the table's base address (28 bits, always aligned to a 32-bit word), a global enable, a 7-bit channel number and an interrupt enable. Software uses it to launch a channel directly, and it passes launch requests from hardware to the engine as well. In both cases it sends the engine a one-clock start pulse that carries the channel number. It keeps a sticky completion interrupt flag that is raised when the engine reports done.

The bus port is a simple single-cycle slave. `bus_addr[2]` selects one of two 32-bit words, and `bus_be` picks the byte lanes. Word 0 holds the base address. It accepts only a full-word write (`bus_be`=1111), or two half-word writes: the low half (`bus_be`=0011, bits 15:0) must come first, then the high half (`bus_be`=1100, bits 27:16). The block holds the low half in a staging register and loads the base only when the high half arrives. Word 1 is the control word. While any transfer is outstanding, the base address is locked against writes.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After reset the base address reads 0x0C003A0, and the control word, `start_o`, `start_sw_o` and `irq_o` all read 0.
- R2: A write to word 0 with `bus_be`=1111 loads the base with `bus_wdata[27:0]` with bits 1:0 forced to 0. Word 0 reads back as {4'b0, base}.
- R3: A `bus_be`=0011 write to word 0 leaves the base unchanged and stages bits 15:0. A following `bus_be`=1100 write loads the base with {`bus_wdata[27:16]`, staged bits}, with bits 1:0 forced to 0. A `bus_be`=1100 write with nothing staged is ignored.
- R4: A write to word 0 with any other strobe pattern, including every single-byte pattern, changes nothing.
- R5: Writes to word 0 are ignored while `eng_busy` is 1, and from a start pulse until the next `eng_done`.
- R6: Control word layout. Bits 6:0 hold the channel number, written through lane 0. Bit 7 is start/busy. Bit 8 is the global enable, written through lane 1. Bit 16 is the interrupt enable and bit 17 the interrupt pending flag, both in lane 2. The other bits read 0.
- R7: Writing 1 to bit 7 through lane 0 while the enable is 1, `eng_busy` is 0 and no transfer is outstanding gives a one-cycle `start_o` in the next cycle. That pulse has `start_chan_o` equal to the written bits 6:0 and `start_sw_o`=1. Writing 0 to bit 7, or writing it while disabled or busy, gives no pulse.
- R8: `hw_req` under the same conditions gives a one-cycle pulse in the next cycle, with `start_chan_o`=`hw_chan` and `start_sw_o`=0. A software launch in the same cycle wins, and the hardware request is dropped.
- R9: Control bit 7 reads 1 from a software launch until `eng_done`. It reads 0 when idle and during transfers launched by hardware.
- R10: `eng_done` sets the pending flag when the interrupt enable is 1, and `irq_o` equals the flag. Writing 1 to bit 17 clears the flag, but a set in the same cycle takes priority. `eng_done` with the interrupt enable at 0 leaves the flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address; bit 2 selects the word, bits 1:0 are ignored |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| eng_busy | input | 1 | Engine is running a transfer |
| eng_done | input | 1 | One-cycle transfer completion strobe |
| hw_req | input | 1 | Hardware launch request |
| hw_chan | input | 7 | Channel for the hardware request |
| start_o | output | 1 | One-cycle launch pulse |
| start_chan_o | output | 7 | Channel for the launch |
| start_sw_o | output | 1 | Launch came from software |
| irq_o | output | 1 | Completion interrupt request |

## Verification
On every cycle, the assertions check that a launch pulse never lasts two cycles and appears only while the block is enabled and the engine idle. They also check that the base address holds steady whenever the engine is busy, that done with the interrupt enable set raises the interrupt, and that the interrupt never rises without such a done. Other behaviours show up only in the bench's scenarios, which run them against a behavioural model: the ordering of half-word writes, rejected strobe patterns, software winning over hardware, the busy readback that depends on where the launch came from, and the case where set and clear of the interrupt arrive together.

// File: rtl/xfer_ctl_pkg.sv
`timescale 1ns/1ps
package xfer_ctl_pkg;
  localparam int BUS_W = 32;
  typedef enum logic [1:0] {
    BW_NONE = 2'd0,
    BW_FULL = 2'd1,
    BW_LO   = 2'd2,
    BW_HI   = 2'd3
  } base_wr_e;
endpackage

// File: rtl/xcr_base.sv
`timescale 1ns/1ps
module xcr_base
  import xfer_ctl_pkg::*;
#(
  parameter int                 BASE_W   = 28,
  parameter int                 LO_W     = 16,
  parameter logic [BASE_W-1:0]  BASE_RST = 28'h0C003A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  base_wr_e          wr_kind,
  input  logic              lock,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BASE_W-1:0] base
);
  localparam int HI_W = BASE_W - LO_W;
  localparam logic [BASE_W-1:0] ALIGN_M = {{(BASE_W-2){1'b1}}, 2'b00};

  logic [BASE_W-1:0] base_q, base_d;
  logic [LO_W-1:0]   stg_q, stg_d;
  logic              stv_q, stv_d;
  logic              ld;

  assign ld = !lock && (wr_kind != BW_NONE);

  always_comb begin
    base_d = base_q;
    stg_d  = stg_q;
    stv_d  = stv_q;
    case (wr_kind)
      BW_FULL: begin
        base_d = wdata[BASE_W-1:0] & ALIGN_M;
        stv_d  = 1'b0;
      end
      BW_LO: begin
        stg_d = wdata[LO_W-1:0];
        stv_d = 1'b1;
      end
      BW_HI: begin
        if (stv_q) begin
          base_d = {wdata[LO_W +: HI_W], stg_q} & ALIGN_M;
          stv_d  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      stg_q  <= '0;
      stv_q  <= 1'b0;
    end else if (ld) begin
      base_q <= base_d;
      stg_q  <= stg_d;
      stv_q  <= stv_d;
    end
  end

  assign base = base_q;
endmodule

// File: rtl/xcr_launch.sv
`timescale 1ns/1ps
module xcr_launch #(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_b0,
  input  logic              wr_b1,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_go,
  input  logic              wr_en,
  input  logic              hw_req,
  input  logic [CHAN_W-1:0] hw_chan,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic [CHAN_W-1:0] chan_q,
  output logic              en_q,
  output logic              sw_busy_q,
  output logic              act_q,
  output logic              pulse_q,
  output logic [CHAN_W-1:0] pchan_q,
  output logic              psw_q
);
  logic can_go, sw_go, hw_go;
  logic act_d, sw_d;

  assign can_go = en_q && !eng_busy && !act_q;
  assign sw_go  = wr_b0 && wr_go && can_go;
  assign hw_go  = hw_req && can_go && !sw_go;

  always_comb begin
    act_d = act_q;
    sw_d  = sw_busy_q;
    if (eng_done) begin
      act_d = 1'b0;
      sw_d  = 1'b0;
    end
    if (sw_go || hw_go) begin
      act_d = 1'b1;
      sw_d  = sw_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      en_q      <= 1'b0;
      sw_busy_q <= 1'b0;
      act_q     <= 1'b0;
      pulse_q   <= 1'b0;
      psw_q     <= 1'b0;
      pchan_q   <= '0;
    end else begin
      if (wr_b0) chan_q <= wr_chan;
      if (wr_b1) en_q   <= wr_en;
      sw_busy_q <= sw_d;
      act_q     <= act_d;
      pulse_q   <= sw_go || hw_go;
      psw_q     <= sw_go;
      if (sw_go || hw_go) pchan_q <= sw_go ? wr_chan : hw_chan;
    end
  end
endmodule

// File: rtl/xcr_irq.sv
`timescale 1ns/1ps
module xcr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_b2,
  input  logic wr_ien,
  input  logic wr_clr,
  input  logic eng_done,
  output logic ien_q,
  output logic pend_q
);
  logic set, pend_d;

  assign set    = eng_done && ien_q;
  assign pend_d = set || (pend_q && !(wr_b2 && wr_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_b2) ien_q <= wr_ien;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/xfer_ctl_regs.sv
`timescale 1ns/1ps
module xfer_ctl_regs
  import xfer_ctl_pkg::*;
#(
  parameter int                BASE_W   = 28,
  parameter int                CHAN_W   = 7,
  parameter int                ADDR_W   = 3,
  parameter logic [BASE_W-1:0] BASE_RST = 28'h0C003A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              hw_req,
  input  logic [CHAN_W-1:0] hw_chan,
  output logic              start_o,
  output logic [CHAN_W-1:0] start_chan_o,
  output logic              start_sw_o,
  output logic              irq_o
);
  localparam int GO_BIT  = 7;
  localparam int EN_BIT  = 8;
  localparam int IEN_BIT = 16;
  localparam int CLR_BIT = 17;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic     wr_w0, wr_w1;
  base_wr_e wr_kind;
  always_comb begin
    wr_w0   = bus_sel && bus_wr && !bus_addr[2];
    wr_w1   = bus_sel && bus_wr &&  bus_addr[2];
    wr_kind = BW_NONE;
    if (wr_w0) begin
      case (bus_be)
        4'b1111: wr_kind = BW_FULL;
        4'b0011: wr_kind = BW_LO;
        4'b1100: wr_kind = BW_HI;
        default: wr_kind = BW_NONE;
      endcase
    end
  end

  logic [BASE_W-1:0] base_q;
  logic [CHAN_W-1:0] chan_q;
  logic              en_q, sw_busy_q, act_q, ien_q, pend_q;

  xcr_base #(.BASE_W(BASE_W), .LO_W(16), .BASE_RST(BASE_RST)) u_base (
    .clk(clk), .rst_n(rst_q_n), .wr_kind(wr_kind),
    .lock(eng_busy || act_q), .wdata(bus_wdata), .base(base_q)
  );

  xcr_launch #(.CHAN_W(CHAN_W)) u_launch (
    .clk(clk), .rst_n(rst_q_n),
    .wr_b0(wr_w1 && bus_be[0]), .wr_b1(wr_w1 && bus_be[1]),
    .wr_chan(bus_wdata[CHAN_W-1:0]), .wr_go(bus_wdata[GO_BIT]),
    .wr_en(bus_wdata[EN_BIT]),
    .hw_req(hw_req), .hw_chan(hw_chan),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .chan_q(chan_q), .en_q(en_q), .sw_busy_q(sw_busy_q), .act_q(act_q),
    .pulse_q(start_o), .pchan_q(start_chan_o), .psw_q(start_sw_o)
  );

  xcr_irq u_irq (
    .clk(clk), .rst_n(rst_q_n), .wr_b2(wr_w1 && bus_be[2]),
    .wr_ien(bus_wdata[IEN_BIT]), .wr_clr(bus_wdata[CLR_BIT]),
    .eng_done(eng_done), .ien_q(ien_q), .pend_q(pend_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[2]) begin
      bus_rdata[BASE_W-1:0] = base_q;
    end else begin
      bus_rdata[CHAN_W-1:0] = chan_q;
      bus_rdata[GO_BIT]     = sw_busy_q;
      bus_rdata[EN_BIT]     = en_q;
      bus_rdata[IEN_BIT]    = ien_q;
      bus_rdata[CLR_BIT]    = pend_q;
    end
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/xfer_ctl_regs_chk.sv
`timescale 1ns/1ps
module xfer_ctl_regs_chk #(
  parameter int BASE_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              start_o,
  input logic              irq_o,
  input logic              en_q,
  input logic              ien_q,
  input logic [BASE_W-1:0] base_q
);
  // R7
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($past(en_q) && !$past(eng_busy)));
  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R5
  base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(base_q));
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && ien_q) |=> irq_o);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !(eng_done && ien_q)) |=> !irq_o);
endmodule

bind xfer_ctl_regs xfer_ctl_regs_chk #(.BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_done(eng_done),
  .start_o(start_o), .irq_o(irq_o), .en_q(en_q), .ien_q(ien_q),
  .base_q(base_q)
);

// File: tb/xfer_ctl_regs_tb.sv
`timescale 1ns/1ps
module xfer_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, eng_done = 1'b0, hw_req = 1'b0;
  logic [6:0]  hw_chan = '0;
  logic        start_o, start_sw_o, irq_o;
  logic [6:0]  start_chan_o;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  xfer_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
    .hw_req(hw_req), .hw_chan(hw_chan), .start_o(start_o),
    .start_chan_o(start_chan_o), .start_sw_o(start_sw_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [27:0] m_base;
  logic [15:0] m_stg;
  bit m_stv, m_en, m_ien, m_pend, m_sw, m_act, m_start, m_ssw;
  logic [6:0] m_chan, m_schan;
  bit w0, w1, lck, cango, swgo, hwgo, iset;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 28'h0C003A0; m_stg = '0; m_stv = 0; m_chan = '0; m_en = 0;
      m_ien = 0; m_pend = 0; m_sw = 0; m_act = 0; m_start = 0; m_ssw = 0;
      m_schan = '0;
    end else begin
      w0    = bus_sel && bus_wr && !bus_addr[2];
      w1    = bus_sel && bus_wr && bus_addr[2];
      lck   = eng_busy || m_act;
      cango = m_en && !eng_busy && !m_act;
      swgo  = w1 && bus_be[0] && bus_wdata[7] && cango;
      hwgo  = hw_req && cango && !swgo;
      iset  = eng_done && m_ien;
      if (w0 && !lck) begin
        if (bus_be == 4'hF) begin
          m_base = bus_wdata[27:0] & 28'hFFFFFFC; m_stv = 0;
        end else if (bus_be == 4'h3) begin
          m_stg = bus_wdata[15:0]; m_stv = 1;
        end else if (bus_be == 4'hC && m_stv) begin
          m_base = {bus_wdata[27:16], m_stg} & 28'hFFFFFFC; m_stv = 0;
        end
      end
      if (w1 && bus_be[0]) m_chan = bus_wdata[6:0];
      if (w1 && bus_be[1]) m_en = bus_wdata[8];
      m_pend = iset || (m_pend && !(w1 && bus_be[2] && bus_wdata[17]));
      if (w1 && bus_be[2]) m_ien = bus_wdata[16];
      if (eng_done) begin m_act = 0; m_sw = 0; end
      m_start = swgo || hwgo;
      m_ssw   = swgo;
      if (swgo) m_schan = bus_wdata[6:0];
      else if (hwgo) m_schan = hw_chan;
      if (swgo || hwgo) begin m_act = 1; m_sw = swgo; end
    end
  end

  function automatic logic [31:0] exp_rd(input logic a2);
    logic [31:0] v = '0;
    if (!a2) v[27:0] = m_base;
    else begin
      v[6:0] = m_chan; v[7] = m_sw; v[8] = m_en; v[16] = m_ien; v[17] = m_pend;
    end
    return v;
  endfunction

  // per-clock comparison of the launch and interrupt outputs
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (start_o !== m_start || start_sw_o !== m_ssw ||
          (m_start && start_chan_o !== m_schan)) begin
        errors++;
        $display("FAIL R7/R8 launch: got start=%0b sw=%0b chan=%0h exp start=%0b sw=%0b chan=%0h",
                 start_o, start_sw_o, start_chan_o, m_start, m_ssw, m_schan);
      end
      vectors++;
      if (irq_o !== m_pend) begin
        errors++;
        $display("FAIL R10 irq: got %0b exp %0b", irq_o, m_pend);
      end
    end
  end

  task automatic wr(input logic a2, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = {a2, 2'b00}; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(input logic a2, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = {a2, 2'b00}; bus_be = 4'hF;
    #5;
    e = exp_rd(a2);
    vectors++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s read word%0d: got %08h exp %08h", tag, a2, bus_rdata, e);
    end
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_busy = 0; eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset values
    rd(0, "R1"); rd(1, "R1");
    // R2 full word, low bits forced to zero
    wr(0, 4'hF, 32'hF234_567F); rd(0, "R2");
    // R3 high half without staged low is ignored
    wr(0, 4'hC, 32'h0ABC_0000); rd(0, "R3");
    // R3 low half staged, base unchanged, then high half commits
    wr(0, 4'h3, 32'h0000_5557); rd(0, "R3");
    wr(0, 4'hC, 32'h0FED_0000); rd(0, "R3");
    // R4 byte and odd strobe patterns ignored
    wr(0, 4'h1, 32'hFFFF_FFFF); wr(0, 4'h6, 32'hFFFF_FFFF);
    wr(0, 4'h8, 32'hFFFF_FFFF); rd(0, "R4");
    // R7 start while disabled: no pulse; R6 channel field written
    wr(1, 4'h1, 32'h0000_0085); rd(1, "R6");
    // R6 enable and interrupt enable
    wr(1, 4'h2, 32'h0000_0100); wr(1, 4'h4, 32'h0001_0000); rd(1, "R6");
    // R7 writing 0 to start bit: no pulse
    wr(1, 4'h1, 32'h0000_0012); rd(1, "R7");
    // R7 software launch on channel 0x2A
    wr(1, 4'h1, 32'h0000_00AA);
    eng_busy = 1;
    rd(1, "R9");
    // R5 base write locked while busy
    wr(0, 4'hF, 32'h0111_1110);
    // R7 second start while busy ignored
    wr(1, 4'h1, 32'h0000_0081);
    done_pulse();
    rd(0, "R5"); rd(1, "R10");
    // R10 clear pending, keep interrupt enable
    wr(1, 4'h4, 32'h0003_0000); rd(1, "R10");
    // R8/R9 hardware launch
    @(negedge clk); hw_req = 1; hw_chan = 7'h11;
    @(negedge clk); hw_req = 0; eng_busy = 1;
    rd(1, "R9");
    // R5 base write locked during hardware transfer too
    wr(0, 4'h3, 32'h0000_1234); wr(0, 4'hC, 32'h0765_0000);
    // R10 done with interrupt enable off leaves flag clear
    wr(1, 4'h4, 32'h0000_0000);
    done_pulse(); rd(1, "R10"); rd(0, "R5");
    // R8 software wins a same-cycle race
    @(negedge clk);
    hw_req = 1; hw_chan = 7'h33;
    bus_sel = 1; bus_wr = 1; bus_addr = 3'b100; bus_be = 4'h1; bus_wdata = 32'h0000_00C4;
    @(negedge clk);
    hw_req = 0; bus_sel = 0; bus_wr = 0; bus_be = '0;
    rd(1, "R8");
    done_pulse();
    // R10 set wins over same-cycle clear
    wr(1, 4'h4, 32'h0001_0000);
    wr(1, 4'h1, 32'h0000_0085);
    eng_busy = 1;
    done_pulse(); rd(1, "R10");
    wr(1, 4'h1, 32'h0000_0090);
    @(negedge clk);
    eng_done = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 3'b100; bus_be = 4'h4; bus_wdata = 32'h0003_0000;
    @(negedge clk);
    eng_done = 0; bus_sel = 0; bus_wr = 0; bus_be = '0;
    rd(1, "R10");
    // R8 hardware request while disabled: no pulse
    wr(1, 4'h2, 32'h0000_0000);
    @(negedge clk); hw_req = 1; hw_chan = 7'h55;
    @(negedge clk); hw_req = 0;
    rd(1, "R8");
    // R2 base writable again when idle
    wr(0, 4'hF, 32'h0000_0003); rd(0, "R2");
    repeat (3) @(negedge clk);
    report();
  end
endmodule